// File: doc/BRIEF.md
# Multi-Mode PRG Bank Selector

This block sits on the write side of a 6502-style cartridge bus and turns the CPU's view of the 0x8000–0xFFFF window into an address into a much larger program ROM. Three banking styles are available: one switchable 32 KiB page, or two 16 KiB halves where the upper half is pinned to the last page of the current group and the lower half is chosen by either four or three inner bits. Which style applies is chosen by two bits of an outer group register. That register is unusual: it is loaded from the low byte of the write *address* in 0x6000–0x7FFF, and only while an unlock bit is set.

Writes anywhere in 0x8000–0xFFFF also land in a data latch that feeds the 32 KiB style and its one-screen nametable choice. A small page at 0x9xxx holds a nametable arrangement register and the unlock register. The ROM address and the nametable arrangement are combinational functions of the current registers and the CPU address, so a read sees its mapping in the same cycle. A power reset clears every register. A separate synchronous soft reset clears only the outer group register.

Top module: `prg_bank_ctrl`

## Requirements
- R1: After power reset (rst_n low), every register is zero: address 0x8000 maps to ROM address 0, address 0xC000 maps to 0x1C000, and ntb_mode is 0 (vertical).
- R2: A write with cpu_addr in 0x6000–0x7FFF while the unlock bit is 1 loads the outer register with cpu_addr[7:0].
- R3: A write in 0x6000–0x7FFF while the unlock bit is 0 leaves the outer register unchanged.
- R4: Every write in 0x8000–0xFFFF stores cpu_wdata in the data latch; only writes in 0x8000–0x8FFF also store cpu_wdata[3:0] in the inner register.
- R5: In 0x9000–0x9FFF, a write with cpu_addr[3:2]=00 loads the arrangement register from cpu_wdata[1:0] and a write with cpu_addr[3:2]=10 loads the unlock bit from cpu_wdata[0]; cpu_addr[3:2]=01 or 11 changes neither.
- R6: With outer bit 3 set, prg_addr = {outer[7:1], latch[2:0], cpu_addr[14:0]}.
- R7: With outer bit 3 set, ntb_mode is 2 when latch bit 4 is 0 and 3 when it is 1, regardless of the arrangement register.
- R8: With outer bits 3:2 = 01, prg_addr = {outer[7:1], q, cpu_addr[13:0]}, where q is inner[3:0] when cpu_addr[14]=0 and 0xF when cpu_addr[14]=1.
- R9: With outer bits 3:2 = 00, prg_addr = {outer[7:0], q, cpu_addr[13:0]}, where q is inner[2:0] when cpu_addr[14]=0 and 7 when cpu_addr[14]=1.
- R10: With outer bit 3 clear, ntb_mode equals the arrangement register: 0 vertical, 1 horizontal, 2 one-screen lower, 3 one-screen upper.
- R11: soft_rst high at a clock edge clears the outer register and leaves inner, latch, arrangement and unlock registers as they were; it takes priority over a simultaneous outer load.
- R12: prg_addr and ntb_mode follow cpu_addr and the register state combinationally, with no clock between an address change and the new output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power reset, asynchronous active low, released through a synchronizer |
| soft_rst | input | 1 | Synchronous soft reset, clears the outer register only |
| cpu_addr | input | 16 | CPU address for both writes and reads |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| prg_addr | output | 25 | Program ROM byte address |
| ntb_mode | output | 2 | Nametable arrangement: 0 vertical, 1 horizontal, 2 one-screen lower, 3 one-screen upper |

## Verification
Register writes take effect at the rising edge that samples cpu_wr, so their results are due one cycle after the strobe; the bench raises cpu_wr at a falling edge, drops it at the next falling edge, and only then probes. The ROM address and nametable arrangement are due with no clock delay after an address change, so the bench sets cpu_addr at a falling edge and reads the outputs one nanosecond later, well away from any rising edge. The power reset passes through a two-stage synchronizer, so the bench waits several cycles after releasing rst_n before its first probe, and the soft reset is held across exactly one rising edge before its result is read.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

  localparam int CPU_AW = 16;
  localparam int DATA_W = 8;

  // page codes on the CPU address
  localparam logic [2:0] CFG_PAGE  = 3'b011;  // 0x6000-0x7FFF
  localparam logic [3:0] LOW_PAGE  = 4'h8;    // 0x8000-0x8FFF
  localparam logic [3:0] CTRL_PAGE = 4'h9;    // 0x9000-0x9FFF
  localparam logic [1:0] SEL_ARR   = 2'b00;   // cpu_addr[3:2] for arrangement
  localparam logic [1:0] SEL_LOCK  = 2'b10;   // cpu_addr[3:2] for unlock

  typedef enum logic [1:0] {
    NT_VERT = 2'd0,
    NT_HORZ = 2'd1,
    NT_LOW  = 2'd2,
    NT_HIGH = 2'd3
  } ntb_e;

  typedef enum logic [1:0] {
    MAP_NARROW16 = 2'd0,
    MAP_WIDE16   = 2'd1,
    MAP_WHOLE32  = 2'd2
  } map_e;

  typedef struct packed {
    logic ld_outer;
    logic ld_inner;
    logic ld_latch;
    logic ld_arr;
    logic ld_lock;
  } wr_stb_t;

endpackage

// File: rtl/prg_rst_sync.sv
module prg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_bank_pkg::*;
(
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              unlock,
  output wr_stb_t           stb
);

  logic in_cfg;
  logic in_rom;
  logic in_low;
  logic in_ctrl;

  always_comb begin
    in_cfg  = (cpu_addr[15:13] == CFG_PAGE);
    in_rom  = cpu_addr[15];
    in_low  = (cpu_addr[15:12] == LOW_PAGE);
    in_ctrl = (cpu_addr[15:12] == CTRL_PAGE);

    stb.ld_outer = cpu_wr && in_cfg && unlock;
    stb.ld_latch = cpu_wr && in_rom;
    stb.ld_inner = cpu_wr && in_low;
    stb.ld_arr   = cpu_wr && in_ctrl && (cpu_addr[3:2] == SEL_ARR);
    stb.ld_lock  = cpu_wr && in_ctrl && (cpu_addr[3:2] == SEL_LOCK);
  end

endmodule

// File: rtl/prg_regs.sv
module prg_regs
  import prg_bank_pkg::*;
#(
  parameter int OUTER_W = 8,
  parameter int INNER_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  wr_stb_t            stb,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [OUTER_W-1:0] outer_q,
  output logic [INNER_W-1:0] inner_q,
  output logic [DATA_W-1:0]  latch_q,
  output logic [1:0]         arr_q,
  output logic               lock_q
);

  logic [OUTER_W-1:0] outer_d;
  logic [INNER_W-1:0] inner_d;
  logic [DATA_W-1:0]  latch_d;
  logic [1:0]         arr_d;
  logic               lock_d;

  // next-state
  always_comb begin
    outer_d = outer_q;
    inner_d = inner_q;
    latch_d = latch_q;
    arr_d   = arr_q;
    lock_d  = lock_q;

    if (soft_rst)          outer_d = '0;
    else if (stb.ld_outer) outer_d = cpu_addr[OUTER_W-1:0];

    if (stb.ld_inner) inner_d = cpu_wdata[INNER_W-1:0];
    if (stb.ld_latch) latch_d = cpu_wdata;
    if (stb.ld_arr)   arr_d   = cpu_wdata[1:0];
    if (stb.ld_lock)  lock_d  = cpu_wdata[0];
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outer_q <= '0;
    end else if (soft_rst || stb.ld_outer) begin
      outer_q <= outer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_q <= '0;
    end else if (stb.ld_inner) begin
      inner_q <= inner_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (stb.ld_latch) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q  <= '0;
      lock_q <= 1'b0;
    end else if (stb.ld_arr || stb.ld_lock) begin
      arr_q  <= arr_d;
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/prg_bank_map.sv
module prg_bank_map
  import prg_bank_pkg::*;
#(
  parameter  int OUTER_W = 8,
  parameter  int INNER_W = 4,
  localparam int PRG_AW  = OUTER_W + 17
) (
  input  logic [OUTER_W-1:0] outer_q,
  input  logic [INNER_W-1:0] inner_q,
  input  logic [DATA_W-1:0]  latch_q,
  input  logic [1:0]         arr_q,
  input  logic [14:0]        rd_addr,
  output logic [PRG_AW-1:0]  prg_addr,
  output ntb_e               ntb_mode
);

  map_e        style;
  logic        hi_half;
  logic [3:0]  wide_sel;
  logic [2:0]  narrow_sel;
  logic        unused_latch;

  assign unused_latch = ^{latch_q[DATA_W-1:5], latch_q[3]};

  always_comb begin
    if (outer_q[3])      style = MAP_WHOLE32;
    else if (outer_q[2]) style = MAP_WIDE16;
    else                 style = MAP_NARROW16;
  end

  always_comb begin
    hi_half    = rd_addr[14];
    wide_sel   = hi_half ? 4'hF : inner_q[3:0];
    narrow_sel = hi_half ? 3'h7 : inner_q[2:0];
  end

  always_comb begin
    unique case (style)
      MAP_WHOLE32:  prg_addr = {outer_q[OUTER_W-1:1], latch_q[2:0], rd_addr[14:0]};
      MAP_WIDE16:   prg_addr = {outer_q[OUTER_W-1:1], wide_sel, rd_addr[13:0]};
      default:      prg_addr = {outer_q, narrow_sel, rd_addr[13:0]};
    endcase
  end

  always_comb begin
    if (style == MAP_WHOLE32) ntb_mode = latch_q[4] ? NT_HIGH : NT_LOW;
    else                      ntb_mode = ntb_e'(arr_q);
  end

endmodule

// File: rtl/prg_bank_ctrl.sv
module prg_bank_ctrl
  import prg_bank_pkg::*;
#(
  parameter  int OUTER_W = 8,
  localparam int PRG_AW  = OUTER_W + 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [1:0]        ntb_mode
);

  localparam int INNER_W = 4;

  logic               rst_ok_n;
  wr_stb_t            stb;
  logic [OUTER_W-1:0] outer_q;
  logic [INNER_W-1:0] inner_q;
  logic [DATA_W-1:0]  latch_q;
  logic [1:0]         arr_q;
  logic               lock_q;
  ntb_e               ntb_sel;

  prg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ok_n)
  );

  prg_wr_decode u_dec (
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .unlock   (lock_q),
    .stb      (stb)
  );

  prg_regs #(.OUTER_W(OUTER_W), .INNER_W(INNER_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .soft_rst  (soft_rst),
    .stb       (stb),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .outer_q   (outer_q),
    .inner_q   (inner_q),
    .latch_q   (latch_q),
    .arr_q     (arr_q),
    .lock_q    (lock_q)
  );

  prg_bank_map #(.OUTER_W(OUTER_W), .INNER_W(INNER_W)) u_map (
    .outer_q  (outer_q),
    .inner_q  (inner_q),
    .latch_q  (latch_q),
    .arr_q    (arr_q),
    .rd_addr  (cpu_addr[14:0]),
    .prg_addr (prg_addr),
    .ntb_mode (ntb_sel)
  );

  assign ntb_mode = ntb_sel;

endmodule

// File: rtl/prg_bank_chk.sv
module prg_bank_chk #(
  parameter  int OUTER_W = 8,
  localparam int PRG_AW  = OUTER_W + 17
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               soft_rst,
  input logic               cpu_wr,
  input logic [15:0]        cpu_addr,
  input logic [7:0]         cpu_wdata,
  input logic [OUTER_W-1:0] outer_q,
  input logic [7:0]         latch_q,
  input logic               lock_q,
  input logic [PRG_AW-1:0]  prg_addr,
  input logic [1:0]         ntb_mode
);

  logic in_cfg;
  logic unused_chk;
  assign in_cfg     = (cpu_addr[15:13] == 3'b011);
  assign unused_chk = ^{prg_addr[PRG_AW-1:17], prg_addr[13:0]};

  assert_outer_load_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_wr && in_cfg && lock_q && !soft_rst) |=> (outer_q == $past(cpu_addr[OUTER_W-1:0])));

  assert_outer_locked_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_wr && in_cfg && !lock_q && !soft_rst) |=> $stable(outer_q));

  assert_latch_store_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_wr && cpu_addr[15]) |=> (latch_q == $past(cpu_wdata)));

  assert_one_screen_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    outer_q[3] |-> (ntb_mode[1] && (ntb_mode[0] == latch_q[4])));

  assert_upper_pinned_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!outer_q[3] && cpu_addr[15:14] == 2'b11) |-> (prg_addr[16:14] == 3'b111));

  assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    soft_rst |=> (outer_q == '0));

endmodule

bind prg_bank_ctrl prg_bank_chk #(.OUTER_W(OUTER_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok_n),
  .soft_rst  (soft_rst),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .outer_q   (outer_q),
  .latch_q   (latch_q),
  .lock_q    (lock_q),
  .prg_addr  (prg_addr),
  .ntb_mode  (ntb_mode)
);

// File: tb/tb_prg_bank_ctrl.sv
module tb_prg_bank_ctrl;

  localparam int CLK_NS = 10;
  localparam int PRG_AW = 25;
  localparam int NVEC   = 7;

  typedef struct packed {
    logic [7:0]        ob;
    logic [7:0]        inner;
    logic [7:0]        latch;
    logic [1:0]        arr;
    logic [15:0]       paddr;
    logic [PRG_AW-1:0] prg;
    logic [1:0]        nt;
  } vec_t;

  // ob, inner, latch, arrangement, probe address, expected ROM address, expected mode
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 8'h05, 8'h00, 2'd1, 16'h8123, 25'h0034123, 2'd1},  // R9 low half
    '{8'h01, 8'h05, 8'h00, 2'd1, 16'hC456, 25'h003C456, 2'd1},  // R9 high half
    '{8'h16, 8'h0B, 8'h00, 2'd2, 16'h9ABC, 25'h02EDABC, 2'd2},  // R8 low half
    '{8'h16, 8'h0B, 8'h00, 2'd3, 16'hFFFF, 25'h02FFFFF, 2'd3},  // R8 high half
    '{8'hAD, 8'h00, 8'h15, 2'd0, 16'hF00F, 25'h15AF00F, 2'd3},  // R6, R7 upper
    '{8'h08, 8'h00, 8'h02, 2'd1, 16'h8001, 25'h0110001, 2'd2},  // R6, R7 lower
    '{8'hF3, 8'h0E, 8'h00, 2'd0, 16'hA000, 25'h1E7A000, 2'd0}   // R9, R10
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              soft_rst;
  logic [15:0]       cpu_addr;
  logic [7:0]        cpu_wdata;
  logic              cpu_wr;
  logic [PRG_AW-1:0] prg_addr;
  logic [1:0]        ntb_mode;

  int n_checks = 0;
  int n_errors = 0;

  prg_bank_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .prg_addr  (prg_addr),
    .ntb_mode  (ntb_mode)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
  endtask

  task automatic probe(input string req, input logic [15:0] a,
                       input logic [PRG_AW-1:0] exp_prg, input logic [1:0] exp_nt);
    cpu_addr = a;
    #1;
    check(req, 32'(prg_addr), 32'(exp_prg));
    check(req, 32'(ntb_mode), 32'(exp_nt));
  endtask

  function automatic string style_req(input logic [7:0] ob);
    if (ob[3])      return "R6 R7";
    else if (ob[2]) return "R8 R10";
    else            return "R9 R10";
  endfunction

  initial begin
    #(CLK_NS * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    soft_rst  = 1'b0;
    cpu_addr  = 16'h0000;
    cpu_wdata = 8'h00;
    cpu_wr    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: cleared state
    probe("R1", 16'h8000, 25'h0000000, 2'd0);
    probe("R1", 16'hC000, 25'h001C000, 2'd0);

    // table walk (R2 loads the outer register every vector)
    for (int i = 0; i < NVEC; i++) begin
      bus_write(16'h9008, 8'h01);                      // unlock
      bus_write({8'h60, VECS[i].ob}, 8'h00);           // R2 outer from address
      bus_write(16'h8000, VECS[i].inner);
      bus_write(16'h9000, {6'd0, VECS[i].arr});
      bus_write(16'hC000, VECS[i].latch);              // latch written last
      probe(style_req(VECS[i].ob), VECS[i].paddr, VECS[i].prg, VECS[i].nt);
    end

    // R3: locked outer write ignored
    bus_write(16'h9008, 8'h01);
    bus_write(16'h6001, 8'h00);
    bus_write(16'h8000, 8'h02);
    bus_write(16'h9000, 8'h00);
    bus_write(16'h9008, 8'h00);                        // lock
    bus_write(16'h6008, 8'h00);
    probe("R3", 16'h8000, 25'h0028000, 2'd0);

    // R4: write above 0x8FFF leaves inner register alone
    bus_write(16'hA000, 8'h07);
    probe("R4", 16'h8000, 25'h0028000, 2'd0);

    // R4: latch taken from a write at 0xE000, seen through the 32 KiB style
    bus_write(16'h9008, 8'h01);
    bus_write(16'h6008, 8'h00);
    bus_write(16'hE000, 8'h13);
    probe("R4 R6 R7", 16'h8000, 25'h0118000, 2'd3);

    // R5: decode of the control page
    bus_write(16'h6001, 8'h00);
    bus_write(16'h9000, 8'h01);
    bus_write(16'h9004, 8'h03);                        // [3:2]=01: no effect
    probe("R5", 16'h8000, 25'h0028000, 2'd1);
    bus_write(16'h900C, 8'h00);                        // [3:2]=11: unlock kept
    bus_write(16'h6002, 8'h00);
    probe("R2 R5", 16'h8000, 25'h0048000, 2'd1);

    // R11: soft reset clears only the outer register
    bus_write(16'h6016, 8'h00);
    bus_write(16'h8000, 8'h0B);
    bus_write(16'h9000, 8'h01);
    probe("R8", 16'h8000, 25'h02EC000, 2'd1);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    probe("R11", 16'h8000, 25'h000C000, 2'd1);
    probe("R11", 16'hC000, 25'h001C000, 2'd1);

    // R11: soft reset wins over a simultaneous unlocked outer load
    @(negedge clk);
    cpu_addr = 16'h6016;
    cpu_wr   = 1'b1;
    soft_rst = 1'b1;
    @(negedge clk);
    cpu_wr   = 1'b0;
    soft_rst = 1'b0;
    probe("R11", 16'h8000, 25'h000C000, 2'd1);

    // R12: output follows address with no clock in between
    probe("R12", 16'h8000, 25'h000C000, 2'd1);
    probe("R12", 16'hBFFF, 25'h000FFFF, 2'd1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule